// File: doc/BRIEF.md
# EDH Flag Update Arbiter

This block settles, once per outgoing error-detection packet, which error flag values go into that packet and whether the checksum words are to be replaced. It handles three flag groups: ancillary, full-field and active-picture. For each group it has several possible sources: the flags decoded from the incoming packet, the error indications computed locally on the data path, override words captured from a parallel flag port, and override words written by a host register interface. The checksum arithmetic and the splicing of words into the stream are outside this block. They appear here only as a build strobe and as the resulting flag and replace-enable outputs.

The precedence is fixed. Bypass mode beats everything and produces all-zero flags with no checksum replacement. The checksum-only mode beats the receive/transmit role, so received flags pass through unchanged. A flag-port write to a group beats a host write to that group. The flag port is an upstream chip's serial feed of select/flag words, and it is held in shadow registers. Its words are accepted only within a latency window after the previous packet was built. All overrides are applied together, as one update, at the next build and are then cleared.

Top module: `edh_flag_arbiter`

## Requirements
- R1: After reset, `out_flags`, `out_stb` and `crc_replace` are all zero.
- R2: A `pkt_build` pulse updates `out_flags` and raises `out_stb` for one cycle on the next clock edge. Between builds, `out_flags` holds its value whatever the other inputs do.
- R3: With `crc_only` high and `bypass` low, each group without an override is output equal to its slice of `rx_flags`, and `loc_err` is ignored whatever `rx_role` is.
- R4: With `crc_only` and `bypass` low, a group without an override is `rx_flags | loc_err` when `rx_role` is high (receive), and `loc_err` alone when `rx_role` is low (transmit).
- R5: With `bypass` high at a build, `out_flags` is zero and `crc_replace` stays low, even when overrides are pending.
- R6: `crc_replace` pulses together with `out_stb` for every build made with `bypass` low.
- R7: A flag-port word with `fp_wr_en` high replaces one group. The `fp_sel` code 01 selects ancillary (bits [FW-1:0]), 00 selects full-field (bits [2FW-1:FW]) and 10 selects active-picture (bits [3FW-1:2FW]). Code 11 is ignored.
- R8: When both the flag port and the host write the same group in one field, the flag-port value is output, whatever their order and also when they arrive in the same cycle.
- R9: A host write (`host_we`, with `host_sel` using the same codes as R7 and 11 ignored) replaces its group when the flag port has not written that group in the current field.
- R10: Overrides last one field. They are cleared by the build that uses them, and a write arriving in the build cycle itself applies to the following build.
- R11: A flag-port write is accepted only on clock edges where at most LINES*CPL-15 cycles have passed since the edge that took the previous build. The first edge after that build counts as cycle 0. Later port words are discarded. Host writes have no such window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_role | input | 1 | 1 = receive role (merge received and local flags), 0 = transmit role (local flags only) |
| crc_only | input | 1 | Checksum-only mode: flags pass through unchanged |
| bypass | input | 1 | Bypass mode: zero flags, no checksum replacement |
| rx_flags | input | 3*FW | Flags decoded from the incoming packet, one FW slice per group |
| loc_err | input | 3*FW | Locally detected error indications, same layout |
| fp_wr_en | input | 1 | Flag-port word valid (downstream write mode) |
| fp_sel | input | 2 | Flag-port group select code |
| fp_flags | input | FW | Flag-port flag word |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host group select code |
| host_flags | input | FW | Host flag word |
| pkt_build | input | 1 | Build strobe for the next outgoing packet |
| out_flags | output | 3*FW | Final flag groups for insertion |
| out_stb | output | 1 | One-cycle pulse marking a fresh `out_flags` value |
| crc_replace | output | 1 | Replace the checksum words in the packet being built |

## Verification
The bench builds the block with FW=5, LINES=2 and CPL=20, which gives a port window of 25 cycles. This short window lets both sides of the window edge (a port write at 25 cycles, accepted, and at 26 cycles, discarded) be hit directly, with no realistic field length to wait through. The narrow flag width keeps the mode sweep small enough to run every one of the eight mode combinations against several arithmetic flag patterns. The override tests cover each select code, including the reserved one, and each ordering of host and port writes.

// File: rtl/edh_arb_pkg.sv
package edh_arb_pkg;

    localparam int NGRP = 3;

    // Group index order inside packed flag vectors
    localparam int GRP_ANC = 0;
    localparam int GRP_FF  = 1;
    localparam int GRP_AP  = 2;

    typedef enum logic [1:0] {
        SEL_FF   = 2'b00,
        SEL_ANC  = 2'b01,
        SEL_AP   = 2'b10,
        SEL_RSVD = 2'b11
    } fsel_e;

    typedef struct packed {
        logic bypass;
        logic crc_only;
        logic rx_role;
    } mode_t;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_PASS,
        SRC_MERGE,
        SRC_LOCAL
    } base_src_e;

    // One-hot group decode of a select code; reserved code gives zero
    function automatic logic [NGRP-1:0] sel_decode(input logic [1:0] sel);
        logic [NGRP-1:0] oh;
        oh = '0;
        case (fsel_e'(sel))
            SEL_ANC: oh[GRP_ANC] = 1'b1;
            SEL_FF:  oh[GRP_FF]  = 1'b1;
            SEL_AP:  oh[GRP_AP]  = 1'b1;
            default: oh = '0;
        endcase
        return oh;
    endfunction

    // Base flag source; bypass beats checksum-only, which beats the role
    function automatic base_src_e pick_base(input mode_t m);
        if (m.bypass)        return SRC_ZERO;
        else if (m.crc_only) return SRC_PASS;
        else if (m.rx_role)  return SRC_MERGE;
        else                 return SRC_LOCAL;
    endfunction

endpackage

// File: rtl/edh_fp_capture.sv
module edh_fp_capture
    import edh_arb_pkg::*;
#(
    parameter int FW    = 5,
    parameter int LINES = 262,
    parameter int CPL   = 1716
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fp_wr_en,
    input  logic [1:0]          fp_sel,
    input  logic [FW-1:0]       fp_flags,
    input  logic                pkt_build,
    output logic [NGRP*FW-1:0]  fp_val,
    output logic [NGRP-1:0]     fp_mark,
    output logic [NGRP-1:0]     fp_take
);
    localparam int LAT = LINES * CPL - 15;
    localparam int CW  = $clog2(LAT + 2);

    logic [CW-1:0]   win_cnt;
    logic            win_open;
    logic [NGRP-1:0] sel_oh;

    // Cycles elapsed since the last build, saturating one past the limit
    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
        end else if (pkt_build) begin
            win_cnt <= '0;
        end else if (win_cnt <= CW'(LAT)) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    // A word in the build cycle belongs to the fresh field
    assign win_open = pkt_build || (win_cnt <= CW'(LAT));
    assign sel_oh   = sel_decode(fp_sel);
    assign fp_take  = (fp_wr_en && win_open) ? sel_oh : '0;

    for (genvar g = 0; g < NGRP; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                fp_mark[g]            <= 1'b0;
                fp_val[g*FW +: FW]    <= '0;
            end else if (fp_take[g]) begin
                fp_mark[g]            <= 1'b1;
                fp_val[g*FW +: FW]    <= fp_flags;
            end else if (pkt_build) begin
                fp_mark[g]            <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/edh_host_shadow.sv
module edh_host_shadow
    import edh_arb_pkg::*;
#(
    parameter int FW = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_we,
    input  logic [1:0]          host_sel,
    input  logic [FW-1:0]       host_flags,
    input  logic                pkt_build,
    input  logic [NGRP-1:0]     fp_mark,
    input  logic [NGRP-1:0]     fp_take,
    output logic [NGRP*FW-1:0]  host_val,
    output logic [NGRP-1:0]     host_mark
);
    logic [NGRP-1:0] sel_oh;
    logic [NGRP-1:0] blocked;
    logic [NGRP-1:0] take;

    assign sel_oh = sel_decode(host_sel);
    // Port ownership of the current field; in the build cycle it is being released
    assign blocked = (pkt_build ? '0 : fp_mark) | fp_take;
    assign take    = host_we ? (sel_oh & ~blocked) : '0;

    for (genvar g = 0; g < NGRP; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                host_mark[g]           <= 1'b0;
                host_val[g*FW +: FW]   <= '0;
            end else if (take[g]) begin
                host_mark[g]           <= 1'b1;
                host_val[g*FW +: FW]   <= host_flags;
            end else if (pkt_build) begin
                host_mark[g]           <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/edh_flag_merge.sv
module edh_flag_merge
    import edh_arb_pkg::*;
#(
    parameter int FW = 5
) (
    input  mode_t               mode,
    input  logic [NGRP*FW-1:0]  rx_flags,
    input  logic [NGRP*FW-1:0]  loc_err,
    input  logic [NGRP*FW-1:0]  fp_val,
    input  logic [NGRP-1:0]     fp_mark,
    input  logic [NGRP*FW-1:0]  host_val,
    input  logic [NGRP-1:0]     host_mark,
    output logic [NGRP*FW-1:0]  flags_next
);
    base_src_e src;
    assign src = pick_base(mode);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [FW-1:0] base;
        always_comb begin
            case (src)
                SRC_PASS:  base = rx_flags[g*FW +: FW];
                SRC_MERGE: base = rx_flags[g*FW +: FW] | loc_err[g*FW +: FW];
                SRC_LOCAL: base = loc_err[g*FW +: FW];
                default:   base = '0;
            endcase
            if (src == SRC_ZERO)
                flags_next[g*FW +: FW] = '0;
            else if (fp_mark[g])
                flags_next[g*FW +: FW] = fp_val[g*FW +: FW];
            else if (host_mark[g])
                flags_next[g*FW +: FW] = host_val[g*FW +: FW];
            else
                flags_next[g*FW +: FW] = base;
        end
    end

endmodule

// File: rtl/edh_flag_arbiter.sv
module edh_flag_arbiter
    import edh_arb_pkg::*;
#(
    parameter int FW    = 5,
    parameter int LINES = 262,
    parameter int CPL   = 1716
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_role,
    input  logic                crc_only,
    input  logic                bypass,
    input  logic [3*FW-1:0]     rx_flags,
    input  logic [3*FW-1:0]     loc_err,
    input  logic                fp_wr_en,
    input  logic [1:0]          fp_sel,
    input  logic [FW-1:0]       fp_flags,
    input  logic                host_we,
    input  logic [1:0]          host_sel,
    input  logic [FW-1:0]       host_flags,
    input  logic                pkt_build,
    output logic [3*FW-1:0]     out_flags,
    output logic                out_stb,
    output logic                crc_replace
);
    logic [NGRP*FW-1:0] fp_val;
    logic [NGRP-1:0]    fp_mark;
    logic [NGRP-1:0]    fp_take;
    logic [NGRP*FW-1:0] host_val;
    logic [NGRP-1:0]    host_mark;
    logic [NGRP*FW-1:0] flags_next;
    mode_t              mode;

    assign mode = '{bypass: bypass, crc_only: crc_only, rx_role: rx_role};

    edh_fp_capture #(.FW(FW), .LINES(LINES), .CPL(CPL)) u_cap (
        .clk(clk), .rst(rst),
        .fp_wr_en(fp_wr_en), .fp_sel(fp_sel), .fp_flags(fp_flags),
        .pkt_build(pkt_build),
        .fp_val(fp_val), .fp_mark(fp_mark), .fp_take(fp_take)
    );

    edh_host_shadow #(.FW(FW)) u_host (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_sel(host_sel), .host_flags(host_flags),
        .pkt_build(pkt_build), .fp_mark(fp_mark), .fp_take(fp_take),
        .host_val(host_val), .host_mark(host_mark)
    );

    edh_flag_merge #(.FW(FW)) u_merge (
        .mode(mode), .rx_flags(rx_flags), .loc_err(loc_err),
        .fp_val(fp_val), .fp_mark(fp_mark),
        .host_val(host_val), .host_mark(host_mark),
        .flags_next(flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_flags   <= '0;
            out_stb     <= 1'b0;
            crc_replace <= 1'b0;
        end else begin
            out_stb     <= pkt_build;
            crc_replace <= pkt_build && !bypass;
            if (pkt_build) out_flags <= flags_next;
        end
    end

endmodule

// File: rtl/edh_flag_arbiter_chk.sv
module edh_flag_arbiter_chk #(
    parameter int FW = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            pkt_build,
    input logic            bypass,
    input logic            crc_only,
    input logic [3*FW-1:0] rx_flags,
    input logic [3*FW-1:0] out_flags,
    input logic            out_stb,
    input logic            crc_replace,
    input logic [3*FW-1:0] fp_val,
    input logic [2:0]      fp_mark,
    input logic [2:0]      fp_take,
    input logic [2:0]      host_mark
);
    // R2
    stb_follows_build_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_build |=> out_stb);

    // R2
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_build |=> $stable(out_flags));

    // R5
    bypass_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_build && bypass) |=> (out_flags == '0 && !crc_replace));

    // R6
    crc_replace_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_build && !bypass) |=> crc_replace);

    // R3
    crc_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_build && crc_only && !bypass && fp_mark == '0 && host_mark == '0)
        |=> (out_flags == $past(rx_flags)));

    // R8
    port_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_build && !bypass && fp_mark[0])
        |=> (out_flags[FW-1:0] == $past(fp_val[FW-1:0])));

    // R10
    marks_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_build && fp_take == '0) |=> (fp_mark == '0));
endmodule

bind edh_flag_arbiter edh_flag_arbiter_chk #(.FW(FW)) u_chk (
    .clk(clk), .rst(rst), .pkt_build(pkt_build), .bypass(bypass),
    .crc_only(crc_only), .rx_flags(rx_flags), .out_flags(out_flags),
    .out_stb(out_stb), .crc_replace(crc_replace), .fp_val(fp_val),
    .fp_mark(fp_mark), .fp_take(fp_take), .host_mark(host_mark)
);

// File: tb/edh_flag_arbiter_tb.sv
module edh_flag_arbiter_tb;
    localparam int FW = 5;
    localparam int LINES = 2;
    localparam int CPL = 20;
    localparam int LAT = LINES * CPL - 15;
    localparam int VW = 3 * FW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_role = 1'b0, crc_only = 1'b0, bypass = 1'b0;
    logic [VW-1:0] rx_flags = '0, loc_err = '0;
    logic fp_wr_en = 1'b0;
    logic [1:0] fp_sel = 2'b00;
    logic [FW-1:0] fp_flags = '0;
    logic host_we = 1'b0;
    logic [1:0] host_sel = 2'b00;
    logic [FW-1:0] host_flags = '0;
    logic pkt_build = 1'b0;
    logic [VW-1:0] out_flags;
    logic out_stb, crc_replace;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    edh_flag_arbiter #(.FW(FW), .LINES(LINES), .CPL(CPL)) u_dut (.*);

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] base_exp(input logic byp, input logic co, input logic role,
                                               input logic [VW-1:0] rx, input logic [VW-1:0] le);
        if (byp) return '0;
        if (co) return rx;
        if (role) return rx | le;
        return le;
    endfunction

    function automatic logic [VW-1:0] put(input logic [VW-1:0] v, input int g, input logic [FW-1:0] w);
        logic [VW-1:0] r;
        r = v;
        r[g*FW +: FW] = w;
        return r;
    endfunction

    // Build then sample at the negedge after the taking edge
    task automatic build(input string req, input logic [VW-1:0] exp, input logic exp_crc);
        pkt_build = 1'b1;
        @(negedge clk);
        pkt_build = 1'b0;
        check(req, out_flags, exp);
        check({req, " stb"}, {14'd0, out_stb}, {14'd0, 1'b1});
        check({req, " crc_replace"}, {14'd0, crc_replace}, {14'd0, exp_crc});
    endtask

    task automatic fp_write(input logic [1:0] sel, input logic [FW-1:0] w);
        fp_wr_en = 1'b1; fp_sel = sel; fp_flags = w;
        repeat (2) @(negedge clk);
        fp_wr_en = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [FW-1:0] w);
        host_we = 1'b1; host_sel = sel; host_flags = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_mode(input logic byp, input logic co, input logic role);
        bypass = byp; crc_only = co; rx_role = role;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [VW-1:0] rxv, lev, held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 flags", out_flags, '0);
        check("R1 stb/crc", {13'd0, out_stb, crc_replace}, '0);
        rst = 1'b0;
        @(negedge clk);

        // R3 R4 R5 R6 sweep over every mode and several patterns
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 4; p++) begin
                rxv = VW'(p * 9157 + m * 311 + 5);
                lev = VW'(p * 4099 + m * 1723 + 17);
                set_mode(m[2], m[1], m[0]);
                rx_flags = rxv; loc_err = lev;
                build($sformatf("R3/R4/R5/R6 mode=%0d pat=%0d", m, p),
                      base_exp(m[2], m[1], m[0], rxv, lev), !m[2]);
            end
        end

        // R2 hold between builds and strobe drop
        set_mode(0, 0, 1);
        rx_flags = 15'h1234; loc_err = 15'h0101;
        build("R2 update", 15'h1335, 1'b1);
        held = 15'h1335;
        rx_flags = 15'h7fff; loc_err = 15'h7fff;
        repeat (3) @(negedge clk);
        check("R2 hold", out_flags, held);
        check("R2 stb low", {14'd0, out_stb}, '0);

        // R7 port select mapping, checksum-only base
        set_mode(0, 1, 0);
        rxv = 15'h2a55; rx_flags = rxv; loc_err = 15'h7fff;
        fp_write(2'b01, 5'h11);
        build("R7 sel01 anc", put(rxv, 0, 5'h11), 1'b1);
        fp_write(2'b00, 5'h0e);
        build("R7 sel00 ff", put(rxv, 1, 5'h0e), 1'b1);
        fp_write(2'b10, 5'h1b);
        build("R7 sel10 ap", put(rxv, 2, 5'h1b), 1'b1);
        fp_write(2'b11, 5'h1f);
        build("R7 sel11 ignored", rxv, 1'b1);

        // R9 host override, each group, reserved code ignored
        set_mode(0, 0, 0);
        lev = 15'h0c63; loc_err = lev;
        for (int g = 0; g < 3; g++) begin
            logic [1:0] sc;
            sc = (g == 0) ? 2'b01 : (g == 1) ? 2'b00 : 2'b10;
            host_write(sc, FW'(g * 7 + 3));
            build($sformatf("R9 host grp=%0d", g), put(lev, g, FW'(g * 7 + 3)), 1'b1);
        end
        host_write(2'b11, 5'h1f);
        build("R9 host sel11 ignored", lev, 1'b1);

        // R8 port beats host in every order
        host_write(2'b00, 5'h05);
        fp_write(2'b00, 5'h0a);
        build("R8 host then port", put(lev, 1, 5'h0a), 1'b1);
        fp_write(2'b10, 5'h0b);
        host_write(2'b10, 5'h04);
        build("R8 port then host", put(lev, 2, 5'h0b), 1'b1);
        host_we = 1'b1; host_sel = 2'b01; host_flags = 5'h02;
        fp_wr_en = 1'b1; fp_sel = 2'b01; fp_flags = 5'h1d;
        @(negedge clk);
        host_we = 1'b0;
        @(negedge clk);
        fp_wr_en = 1'b0;
        build("R8 same cycle", put(lev, 0, 5'h1d), 1'b1);

        // R10 overrides cleared after use
        build("R10 cleared", lev, 1'b1);
        // R10 write in the build cycle applies to the following build
        host_we = 1'b1; host_sel = 2'b10; host_flags = 5'h16;
        build("R10 build-cycle write not yet", lev, 1'b1);
        host_we = 1'b0;
        build("R10 build-cycle write next", put(lev, 2, 5'h16), 1'b1);

        // R5 bypass discards pending overrides
        fp_write(2'b01, 5'h1f);
        host_write(2'b00, 5'h1f);
        set_mode(1, 0, 1);
        build("R5 bypass overrides", '0, 1'b0);
        set_mode(0, 0, 0);
        build("R5 overrides gone", lev, 1'b1);

        // R11 window edge: LAT cycles accepted, LAT+1 discarded
        repeat (LAT) @(negedge clk);
        fp_write(2'b01, 5'h09);
        build("R11 last open cycle", put(lev, 0, 5'h09), 1'b1);
        repeat (LAT + 1) @(negedge clk);
        fp_write(2'b01, 5'h09);
        build("R11 past window", lev, 1'b1);
        repeat (LAT + 4) @(negedge clk);
        host_write(2'b01, 5'h07);
        build("R11 host not windowed", put(lev, 0, 5'h07), 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule